// File: doc/BRIEF.md
# Secured Memory Access Guard

This block sits on the CPU bus in front of the on-chip program ROM, the on-chip RAM and the configuration register bank. In each cycle it decodes the presented address into a region select. It then weighs the access kind, the programming-mode flag and the 2-bit security level to decide one of three outcomes. The access is passed through, its write is inhibited, or the data handed back to the CPU is replaced by a substitute byte.

Substitution has two forms. In the first, a ROM read returns the constant 0xFF. In the second, a programming-mode ROM read at level 1 returns the ROM byte XORed with a mask. The mask is the parameter `SCRAMBLE_KEY` XORed with every byte of the address. Runtime operand protection depends on the most recent opcode fetch, so the block keeps one flag that records whether that fetch hit on-chip ROM.

The access interface is a valid-only stream. `acc_valid` marks a live access, and the guard never applies back-pressure, so every valid cycle is evaluated in the same cycle. All outputs are combinational in the current inputs and that one flag.

Top module: `rom_guard`

## Requirements
- R1: In running mode (`prog_mode`=0) the select decode is as follows. 0x0000–0x01FF selects RAM. 0x0200–0x02FF selects RAM only when `ram_hi_en`=1. 0xE000–0xFFFF selects ROM. 0xC000–0xDFFF selects ROM only when `rom_lo_en`=1. The config bank is never selected, no other address selects anything, and at most one select is high.
- R2: In programming mode, 0x0000–0x3FFF selects ROM whatever the enable bits are, and 0x7FF0–0x7FFF selects the config bank. No other address selects anything.
- R3: A write (`acc_kind`=2) to ROM or to the config bank raises `wr_inhibit` in these cases: at levels 0, 1 and 2; at any level in running mode; and only in programming mode at level 3 is it allowed. Writes to RAM are never inhibited.
- R4: At levels 3 and 2, programming-mode reads of ROM and config are returned unmodified (`subst_en`=0).
- R5: At level 1, a programming-mode ROM read raises `subst_en` with `subst_data` = `rom_data` ^ `SCRAMBLE_KEY` ^ `addr[15:8]` ^ `addr[7:0]`.
- R6: At level 0, a programming-mode ROM read substitutes 0xFF. Config reads are unmodified at every level.
- R7: At levels 0 and 1 in running mode, an operand read (kind 1, and kinds 5–7, which are treated as operand reads) of ROM substitutes 0xFF when the latest opcode fetch (kind 0) was outside ROM, and is unmodified when that fetch hit ROM. Levels 2 and 3 never substitute in running mode.
- R8: The ROM-origin flag is cleared by reset. It is loaded only by a valid opcode fetch and holds through every other access kind.
- R9: Vector fetches (kind 3) and control-transfer fetches (kind 4) are never substituted in running mode, and they do not change the flag.
- R10: With `acc_valid`=0 all selects, `wr_inhibit`, `subst_en` and `subst_data` are 0, and the flag is left unchanged. `subst_data` is 0 whenever `subst_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 16 | Bus address |
| acc_kind | input | 3 | 0 opcode fetch, 1 operand read, 2 write, 3 vector fetch, 4 control transfer, 5–7 operand read |
| prog_mode | input | 1 | 1 = programming mode, 0 = running mode |
| sec_level | input | 2 | Security level, 3 unsecured down to 0 strictest |
| rom_lo_en | input | 1 | Enables optional ROM half in running mode |
| ram_hi_en | input | 1 | Enables optional upper RAM page |
| rom_data | input | 8 | Byte read from ROM this cycle |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_cfg | output | 1 | Config bank select |
| wr_inhibit | output | 1 | Suppress the write |
| subst_en | output | 1 | Replace read data with `subst_data` |
| subst_data | output | 8 | Substitute byte |

## Verification
The bench builds the guard with its default parameters: 16-bit addresses and `SCRAMBLE_KEY` = 0x5A. With these values every range edge of both address maps can be hit directly. The scramble mask can also be computed by hand (for example 0x1234 with data 0x00 gives 0x7C). A short directed run steps the flag through ROM, RAM, vector and transfer fetches, and through an idle cycle, to reach the history-dependent operand cases.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [2:0] {
    AK_OPFETCH = 3'd0,
    AK_OPERAND = 3'd1,
    AK_WRITE   = 3'd2,
    AK_VECTOR  = 3'd3,
    AK_XFER    = 3'd4
  } acc_kind_e;

  typedef struct packed {
    logic ram;
    logic rom;
    logic cfg;
  } region_t;

  localparam logic [1:0] LVL_OPEN = 2'd3;
  localparam logic [1:0] LVL_RO   = 2'd2;
  localparam logic [1:0] LVL_ENC  = 2'd1;
  localparam logic [1:0] LVL_LOCK = 2'd0;
endpackage

// File: rtl/rg_decode.sv
module rg_decode
  import rg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RAM_FIX_LAST  = 'h01FF,
  parameter logic [AW-1:0] RAM_OPT_FIRST = 'h0200,
  parameter logic [AW-1:0] RAM_OPT_LAST  = 'h02FF,
  parameter logic [AW-1:0] ROM_OPT_FIRST = 'hC000,
  parameter logic [AW-1:0] ROM_FIX_FIRST = 'hE000,
  parameter logic [AW-1:0] PROG_ROM_LAST = 'h3FFF,
  parameter logic [AW-1:0] CFG_FIRST     = 'h7FF0,
  parameter logic [AW-1:0] CFG_LAST      = 'h7FFF
) (
  input  logic [AW-1:0] addr,
  input  logic          prog_mode,
  input  logic          rom_lo_en,
  input  logic          ram_hi_en,
  output region_t       hit
);
  logic in_ram_fix, in_ram_opt, in_rom_fix, in_rom_opt;

  always_comb begin
    in_ram_fix = (addr <= RAM_FIX_LAST);
    in_ram_opt = (addr >= RAM_OPT_FIRST) && (addr <= RAM_OPT_LAST);
    in_rom_fix = (addr >= ROM_FIX_FIRST);
    in_rom_opt = (addr >= ROM_OPT_FIRST) && (addr < ROM_FIX_FIRST);
    hit = '0;
    if (prog_mode) begin
      hit.rom = (addr <= PROG_ROM_LAST);
      hit.cfg = (addr >= CFG_FIRST) && (addr <= CFG_LAST);
    end else begin
      hit.ram = in_ram_fix || (in_ram_opt && ram_hi_en);
      hit.rom = in_rom_fix || (in_rom_opt && rom_lo_en);
    end
  end
endmodule

// File: rtl/rg_scramble.sv
module rg_scramble #(
  parameter int AW = 16,
  parameter logic [7:0] KEY = 8'h5A
) (
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);
  localparam int NB = (AW + 7) / 8;
  localparam int PW = NB * 8;

  logic [PW-1:0] addr_pad;
  logic [7:0]    fold [NB+1];

  assign addr_pad = PW'(addr);
  assign fold[0]  = KEY ^ din;

  for (genvar b = 0; b < NB; b++) begin : g_fold
    assign fold[b+1] = fold[b] ^ addr_pad[b*8 +: 8];
  end

  assign dout = fold[NB];
endmodule

// File: rtl/rg_optrack.sv
module rg_optrack (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_stb,
  input  logic fetch_in_rom,
  output logic from_rom
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         from_rom <= 1'b0;
    else if (fetch_stb) from_rom <= fetch_in_rom;
  end

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |=> (from_rom == $past(fetch_in_rom))); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |=> $stable(from_rom)); // R8
endmodule

// File: rtl/rom_guard.sv
module rom_guard
  import rg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [7:0] SCRAMBLE_KEY = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [2:0]    acc_kind,
  input  logic          prog_mode,
  input  logic [1:0]    sec_level,
  input  logic          rom_lo_en,
  input  logic          ram_hi_en,
  input  logic [7:0]    rom_data,
  output logic          sel_ram,
  output logic          sel_rom,
  output logic          sel_cfg,
  output logic          wr_inhibit,
  output logic          subst_en,
  output logic [7:0]    subst_data
);
  region_t   hit;
  acc_kind_e kind;
  logic      from_rom, fetch_stb;
  logic      is_write, is_operand, is_read;
  logic [7:0] scrambled;

  assign kind = acc_kind_e'(acc_kind);

  rg_decode #(.AW(AW)) u_decode (
    .addr(acc_addr), .prog_mode(prog_mode),
    .rom_lo_en(rom_lo_en), .ram_hi_en(ram_hi_en), .hit(hit)
  );

  rg_scramble #(.AW(AW), .KEY(SCRAMBLE_KEY)) u_scramble (
    .addr(acc_addr), .din(rom_data), .dout(scrambled)
  );

  assign fetch_stb = acc_valid && (kind == AK_OPFETCH);

  rg_optrack u_track (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb),
    .fetch_in_rom(hit.rom), .from_rom(from_rom)
  );

  always_comb begin
    is_write   = (kind == AK_WRITE);
    is_read    = !is_write;
    is_operand = !(kind inside {AK_OPFETCH, AK_WRITE, AK_VECTOR, AK_XFER});
    sel_ram    = acc_valid && hit.ram;
    sel_rom    = acc_valid && hit.rom;
    sel_cfg    = acc_valid && hit.cfg;
    wr_inhibit = acc_valid && is_write && (hit.rom || hit.cfg) &&
                 !(prog_mode && sec_level == LVL_OPEN);
    subst_en   = 1'b0;
    subst_data = 8'h00;
    if (acc_valid && is_read && hit.rom) begin
      if (prog_mode) begin
        if (sec_level == LVL_ENC) begin
          subst_en   = 1'b1;
          subst_data = scrambled;
        end else if (sec_level == LVL_LOCK) begin
          subst_en   = 1'b1;
          subst_data = 8'hFF;
        end
      end else if (!sec_level[1] && is_operand && !from_rom) begin
        subst_en   = 1'b1;
        subst_data = 8'hFF;
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram, sel_rom, sel_cfg})); // R1
  AST_CFG_WR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 3'd2 && sel_cfg && sec_level != 2'd3) |-> wr_inhibit); // R3
  AST_RAM_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> !wr_inhibit && !subst_en); // R3
  AST_L0_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && sec_level == 2'd0 && sel_rom && acc_kind != 3'd2) |-> (subst_en && subst_data == 8'hFF)); // R6
  AST_VEC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && (acc_kind == 3'd3 || acc_kind == 3'd4)) |-> !subst_en); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(sel_ram || sel_rom || sel_cfg || wr_inhibit || subst_en) && subst_data == 8'h00); // R10
endmodule

// File: tb/tb_rom_guard.sv
module tb_rom_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [2:0] acc_kind = '0;
  logic       prog_mode = 1'b0;
  logic [1:0] sec_level = 2'd3;
  logic       rom_lo_en = 1'b1, ram_hi_en = 1'b1;
  logic [7:0] rom_data = '0;
  logic       sel_ram, sel_rom, sel_cfg, wr_inhibit, subst_en;
  logic [7:0] subst_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rom_guard dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .prog_mode(prog_mode), .sec_level(sec_level),
    .rom_lo_en(rom_lo_en), .ram_hi_en(ram_hi_en), .rom_data(rom_data),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_cfg(sel_cfg),
    .wr_inhibit(wr_inhibit), .subst_en(subst_en), .subst_data(subst_data)
  );

  // {req, addr, rom_data, kind, prog, level, rom_lo_en, ram_hi_en,
  //  exp {ram,rom,cfg}, exp wr_inhibit, exp subst_en, exp subst_data}
  localparam int NV = 26;
  localparam logic [48:0] VEC [NV] = '{
    {4'd1, 16'h0100, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1, 16'h0250, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1, 16'h02FF, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1, 16'hC010, 8'h00, 3'd1, 1'b0, 2'd3, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1, 16'hDFFF, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}, // R1
    {4'd7, 16'hE000, 8'h00, 3'd1, 1'b0, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}, // R7 level 2 free
    {4'd1, 16'h7FF5, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 8'h00}, // R1
    {4'd1, 16'h0300, 8'h00, 3'd1, 1'b0, 2'd3, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 8'h00}, // R1
    {4'd2, 16'h0010, 8'h33, 3'd1, 1'b1, 2'd3, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0, 8'h00}, // R2
    {4'd2, 16'h7FF3, 8'h00, 3'd1, 1'b1, 2'd3, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 8'h00}, // R2
    {4'd2, 16'h5000, 8'h00, 3'd1, 1'b1, 2'd3, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 8'h00}, // R2
    {4'd2, 16'hE000, 8'h00, 3'd1, 1'b1, 2'd3, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 8'h00}, // R2
    {4'd3, 16'h0010, 8'h00, 3'd2, 1'b1, 2'd3, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}, // R3
    {4'd3, 16'h0010, 8'h00, 3'd2, 1'b1, 2'd2, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0, 8'h00}, // R3
    {4'd3, 16'h7FF0, 8'h00, 3'd2, 1'b1, 2'd1, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 8'h00}, // R3
    {4'd3, 16'h7FF0, 8'h00, 3'd2, 1'b1, 2'd0, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 8'h00}, // R3
    {4'd3, 16'hE000, 8'h00, 3'd2, 1'b0, 2'd3, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0, 8'h00}, // R3
    {4'd3, 16'h0100, 8'h00, 3'd2, 1'b0, 2'd0, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0, 8'h00}, // R3
    {4'd4, 16'h2000, 8'h77, 3'd1, 1'b1, 2'd2, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}, // R4
    {4'd5, 16'h1234, 8'h00, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 3'b010, 1'b0, 1'b1, 8'h7C}, // R5
    {4'd5, 16'h3F01, 8'hA5, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 3'b010, 1'b0, 1'b1, 8'hC1}, // R5
    {4'd6, 16'h7FF2, 8'h00, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 8'h00}, // R6
    {4'd6, 16'h0100, 8'h12, 3'd1, 1'b1, 2'd0, 1'b1, 1'b1, 3'b010, 1'b0, 1'b1, 8'hFF}, // R6
    {4'd6, 16'h7FFF, 8'h00, 3'd1, 1'b1, 2'd0, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 8'h00}, // R6
    {4'd9, 16'hFFFE, 8'h00, 3'd3, 1'b0, 2'd0, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}, // R9
    {4'd9, 16'hE100, 8'h00, 3'd4, 1'b0, 2'd1, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0, 8'h00}  // R9
  };

  task automatic chk(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [12:0] outs();
    return {sel_ram, sel_rom, sel_cfg, wr_inhibit, subst_en, subst_data};
  endfunction

  task automatic drive(input bit v, input logic [15:0] a, input logic [2:0] k,
                       input bit p, input logic [1:0] l);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_kind = k; prog_mode = p; sec_level = l;
    #5;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 chk("R10 reset idle", outs(), 13'h0);
    @(negedge clk) rst_n = 1'b1;

    // R8: flag clear after reset -> running-mode operand read of ROM at level 1 blanks
    rom_lo_en = 1'b1; ram_hi_en = 1'b1; rom_data = 8'h3C;
    drive(1, 16'hE000, 3'd1, 0, 2'd1);
    chk("R8 reset flag", outs(), {3'b010, 1'b0, 1'b1, 8'hFF});

    // R7: opcode from ROM, operand of ROM plain
    drive(1, 16'hE010, 3'd0, 0, 2'd1);
    chk("R7 rom opfetch", outs(), {3'b010, 1'b0, 1'b0, 8'h00});
    drive(1, 16'hE020, 3'd1, 0, 2'd1);
    chk("R7 rom-origin operand", outs(), {3'b010, 1'b0, 1'b0, 8'h00});
    drive(1, 16'hC020, 3'd6, 0, 2'd0);
    chk("R7 kind6 rom-origin", outs(), {3'b010, 1'b0, 1'b0, 8'h00});

    // R7: opcode from RAM, operand of ROM blanked
    drive(1, 16'h0150, 3'd0, 0, 2'd0);
    drive(1, 16'hF000, 3'd1, 0, 2'd0);
    chk("R7 ram-origin operand", outs(), {3'b010, 1'b0, 1'b1, 8'hFF});
    drive(1, 16'hF000, 3'd1, 0, 2'd2);
    chk("R7 level2 unprotected", outs(), {3'b010, 1'b0, 1'b0, 8'h00});

    // R9: vector and transfer into ROM not blanked and do not load flag
    drive(1, 16'hFFFE, 3'd3, 0, 2'd1);
    chk("R9 vector", outs(), {3'b010, 1'b0, 1'b0, 8'h00});
    drive(1, 16'hE400, 3'd4, 0, 2'd1);
    chk("R9 transfer", outs(), {3'b010, 1'b0, 1'b0, 8'h00});
    drive(1, 16'hF001, 3'd1, 0, 2'd1);
    chk("R8 flag held", outs(), {3'b010, 1'b0, 1'b1, 8'hFF});

    // R10: idle opfetch in ROM ignored
    drive(0, 16'hE000, 3'd0, 0, 2'd1);
    chk("R10 idle outputs", outs(), 13'h0);
    drive(1, 16'hF002, 3'd1, 0, 2'd1);
    chk("R10 flag unchanged", outs(), {3'b010, 1'b0, 1'b1, 8'hFF});

    // table walk (no opcode fetches, no history-dependent rows)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = 1'b1;
      acc_addr  = VEC[i][44:29];
      rom_data  = VEC[i][28:21];
      acc_kind  = VEC[i][20:18];
      prog_mode = VEC[i][17];
      sec_level = VEC[i][16:15];
      rom_lo_en = VEC[i][14];
      ram_hi_en = VEC[i][13];
      #5 chk($sformatf("R%0d row %0d", VEC[i][48:45], i), outs(), VEC[i][12:0]);
    end

    // R2: programming mode ignores rom_lo_en for the low half
    rom_lo_en = 1'b0;
    drive(1, 16'h3FFF, 3'd1, 1, 2'd3);
    chk("R2 prog top edge", outs(), {3'b010, 1'b0, 1'b0, 8'h00});
    drive(1, 16'h4000, 3'd1, 1, 2'd3);
    chk("R2 prog past edge", outs(), 13'h0);

    drive(0, 16'h0000, 3'd0, 0, 2'd3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule